// File: doc/BRIEF.md
# Timed Toggle Playback Engine

This block replays a stream of precomputed edge events onto twelve output lines. A producer elsewhere in the chip writes fixed-size records into a 64-record ring of byte slots. Each record holds a toggle mask and a wait code. The engine fetches the record at its read pointer and flips every output whose mask bit is set. It then counts out the wait encoded in that record before it consumes the next one. All edges therefore fall on exact system-clock boundaries, and their spacing is set only by the data. The intended use is a bank of square-wave tone sources whose half-periods were computed ahead of time. The spacing of the records is a whole multiple of 20 clocks, which is one microsecond at a 20 MHz system clock.

The ring is read through a combinational port: the engine presents a byte address and sees the whole 32-bit record in the same cycle. It exports that address so the producer knows which slots are free. The producer returns its own write pointer, and the ring counts as empty when the two pointers are equal. After reset the engine waits a fixed hold-off before it applies the first record, which gives the producer time to fill the ring. If a record is due while the ring is empty, the outputs freeze and a sticky flag records the starvation. The engine applies the record on the first cycle in which one is present.

Top module: `toggle_player`

## Requirements
- R1: While reset is asserted, and after it is released, tone_o is 0, rd_ptr_o is 0 and underrun_o is 0 until the first record is applied.
- R2: The first record is applied on the 2048th rising clock edge after reset is released, and no output changes before that edge.
- R3: Record layout: bits [7:0] toggle tone_o[7:0], bits [11:8] toggle tone_o[11:8], bits [23:16] hold the wait code, and bits [15:12] and [31:24] have no effect on any output.
- R4: Applying a record XORs its 12-bit mask into tone_o on a single clock edge. Exactly the lines whose mask bits are 1 change, and a zero mask changes nothing.
- R5: When a record with wait code d has been applied, the next record is applied exactly (d+1)*20 clock edges later, and tone_o does not change in between. Code 0 gives 20 clocks and code 255 gives 5120.
- R6: Each applied record advances rd_ptr_o by 4. The pointer stays a multiple of 4 and wraps from 252 to 0.
- R7: If a record is due while rd_ptr_o equals wr_ptr_i, then tone_o and rd_ptr_o hold, underrun_o goes to 1 on that edge, and the record is applied on the first edge at which the pointers differ.
- R8: underrun_o stays at 1 until reset, even after records arrive again.
- R9: After a late record from R7 is applied, the wait before the next record is counted from the edge on which the late record was applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one wait unit is 20 of its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_i | input | 32 | Ring data at byte address rd_ptr_o, valid in the same cycle |
| wr_ptr_i | input | 8 | Producer's next write byte address; equal to rd_ptr_o means empty |
| rd_ptr_o | output | 8 | Byte address of the next record to apply; also tells the producer which slots are free |
| tone_o | output | 12 | Toggled output lines |
| underrun_o | output | 1 | Sticky flag: a record fell due while the ring was empty |

## Verification
The assertions assume that the ring returns stable record data for the current rd_ptr_o within the same cycle. They also assume that the producer only advances wr_ptr_i in steps of 4 and never catches up to rd_ptr_o from behind. Under those assumptions a pointer move always means a real record was applied. The bench acts as a producer that keeps at least one slot empty and writes only on falling clock edges into slots the engine is not reading. It lets the ring run dry only in the starvation scenario, where it then writes the late records directly.

// File: rtl/tgp_pkg.sv
package tgp_pkg;

    // Default geometry of the playback engine.
    localparam int TGP_TONE_W    = 12;   // output lines
    localparam int TGP_LOW_W     = 8;    // lines fed from the first mask byte
    localparam int TGP_DLY_W     = 8;    // wait-code width
    localparam int TGP_REC_BYTES = 4;    // byte slots per record
    localparam int TGP_PTR_W     = 8;    // byte address width of the ring
    localparam int TGP_UNIT      = 20;   // clocks per wait unit
    localparam int TGP_HOLDOFF   = 2048; // clocks before the first record

    // Width of a down-counter that must hold both the hold-off and the
    // longest record spacing.
    function automatic int tgp_cnt_w(input int dly_w, input int unit, input int holdoff);
        int span;
        span = (1 << dly_w) * unit;
        if (holdoff > span) begin
            span = holdoff;
        end
        return $clog2(span + 1);
    endfunction

endpackage

// File: rtl/tgp_rec_unpack.sv
module tgp_rec_unpack
    import tgp_pkg::*;
#(
    parameter int TONE_W    = TGP_TONE_W,
    parameter int LOW_W     = TGP_LOW_W,
    parameter int DLY_W     = TGP_DLY_W,
    parameter int REC_BYTES = TGP_REC_BYTES,
    parameter int UNIT      = TGP_UNIT,
    parameter int CNT_W     = 13
) (
    input  logic [8*REC_BYTES-1:0] rec_i,
    output logic [TONE_W-1:0]      mask_o,
    output logic [CNT_W-1:0]       reload_o
);
    localparam int HI_W    = TONE_W - LOW_W;
    localparam int DLY_LSB = 16;

    logic [DLY_W-1:0] code_w;
    logic             pad_unused;

    assign code_w = rec_i[DLY_LSB +: DLY_W];

    // Mask lanes: the low group from byte 0, the optional high group from byte 1.
    generate
        if (HI_W > 0) begin : g_two_groups
            assign mask_o     = {rec_i[8 +: HI_W], rec_i[0 +: LOW_W]};
            assign pad_unused = ^{rec_i[8*REC_BYTES-1:DLY_LSB+DLY_W], rec_i[15:8+HI_W]};
        end else begin : g_one_group
            assign mask_o     = rec_i[0 +: TONE_W];
            assign pad_unused = ^{rec_i[8*REC_BYTES-1:DLY_LSB+DLY_W], rec_i[15:TONE_W]};
        end
    endgenerate

    // Spacing in clocks: (code + 1) wait units.
    always_comb begin
        reload_o = CNT_W'((32'(code_w) + 32'd1) * 32'(UNIT));
    end

endmodule

// File: rtl/tgp_interval_timer.sv
module tgp_interval_timer
    import tgp_pkg::*;
#(
    parameter int CNT_W   = 13,
    parameter int HOLDOFF = TGP_HOLDOFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             due_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_q, st_d;

    assign due_o = (st_q.cnt == CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (due_o) begin
            // Stay due until a record is actually taken.
            if (advance_i) begin
                st_d.cnt = reload_i;
            end
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= CNT_W'(HOLDOFF);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tgp_ring_reader.sv
module tgp_ring_reader
    import tgp_pkg::*;
#(
    parameter int PTR_W     = TGP_PTR_W,
    parameter int REC_BYTES = TGP_REC_BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             due_i,
    input  logic [PTR_W-1:0] wr_ptr_i,
    output logic [PTR_W-1:0] rd_ptr_o,
    output logic             advance_o,
    output logic             underrun_o
);
    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             starved;
    } rdr_t;

    rdr_t st_q, st_d;
    logic empty_w;

    assign empty_w    = (st_q.ptr == wr_ptr_i);
    assign advance_o  = due_i && !empty_w;
    assign rd_ptr_o   = st_q.ptr;
    assign underrun_o = st_q.starved;

    always_comb begin
        st_d = st_q;
        if (advance_o) begin
            st_d.ptr = st_q.ptr + PTR_W'(REC_BYTES);
        end
        if (due_i && empty_w) begin
            st_d.starved = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/tgp_toggle_bank.sv
module tgp_toggle_bank
    import tgp_pkg::*;
#(
    parameter int TONE_W = TGP_TONE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              apply_i,
    input  logic [TONE_W-1:0] mask_i,
    output logic [TONE_W-1:0] tone_o
);
    typedef struct packed {
        logic [TONE_W-1:0] tone;
    } bank_t;

    bank_t st_q, st_d;

    assign tone_o = st_q.tone;

    // Per-line flip enable; every line of a record flips on the same edge.
    always_comb begin
        st_d = st_q;
        for (int b = 0; b < TONE_W; b++) begin
            st_d.tone[b] = st_q.tone[b] ^ (apply_i & mask_i[b]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/toggle_player.sv
module toggle_player
    import tgp_pkg::*;
#(
    parameter int TONE_W    = TGP_TONE_W,
    parameter int LOW_W     = TGP_LOW_W,
    parameter int DLY_W     = TGP_DLY_W,
    parameter int REC_BYTES = TGP_REC_BYTES,
    parameter int PTR_W     = TGP_PTR_W,
    parameter int UNIT      = TGP_UNIT,
    parameter int HOLDOFF   = TGP_HOLDOFF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [8*REC_BYTES-1:0] rec_i,
    input  logic [PTR_W-1:0]       wr_ptr_i,
    output logic [PTR_W-1:0]       rd_ptr_o,
    output logic [TONE_W-1:0]      tone_o,
    output logic                   underrun_o
);
    localparam int CNT_W = tgp_cnt_w(DLY_W, UNIT, HOLDOFF);

    logic [TONE_W-1:0] mask_w;
    logic [CNT_W-1:0]  reload_w;
    logic              due_w;
    logic              adv_w;

    tgp_rec_unpack #(
        .TONE_W   (TONE_W),
        .LOW_W    (LOW_W),
        .DLY_W    (DLY_W),
        .REC_BYTES(REC_BYTES),
        .UNIT     (UNIT),
        .CNT_W    (CNT_W)
    ) u_unpack (
        .rec_i   (rec_i),
        .mask_o  (mask_w),
        .reload_o(reload_w)
    );

    tgp_interval_timer #(
        .CNT_W  (CNT_W),
        .HOLDOFF(HOLDOFF)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance_i(adv_w),
        .reload_i (reload_w),
        .due_o    (due_w)
    );

    tgp_ring_reader #(
        .PTR_W    (PTR_W),
        .REC_BYTES(REC_BYTES)
    ) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .due_i     (due_w),
        .wr_ptr_i  (wr_ptr_i),
        .rd_ptr_o  (rd_ptr_o),
        .advance_o (adv_w),
        .underrun_o(underrun_o)
    );

    tgp_toggle_bank #(
        .TONE_W(TONE_W)
    ) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .apply_i(adv_w),
        .mask_i (mask_w),
        .tone_o (tone_o)
    );

endmodule

// File: rtl/tgp_player_checker.sv
module tgp_player_checker #(
    parameter int TONE_W    = 12,
    parameter int REC_BYTES = 4,
    parameter int PTR_W     = 8,
    parameter int UNIT      = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              due_i,
    input logic [PTR_W-1:0]  wr_ptr_i,
    input logic [PTR_W-1:0]  rd_ptr_o,
    input logic [TONE_W-1:0] tone_o,
    input logic              underrun_o
);
    localparam int GAP_W = $clog2(UNIT + 1);

    logic [PTR_W-1:0] ptr_prev_q;
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;
    logic             moved;

    assign moved = (rd_ptr_o != ptr_prev_q);

    // Cycles since the last pointer move, saturating at one unit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_prev_q <= '0;
            gap_q      <= '0;
            seen_q     <= 1'b0;
        end else begin
            ptr_prev_q <= rd_ptr_o;
            if (moved) begin
                gap_q  <= '0;
                seen_q <= 1'b1;
            end else if (gap_q != GAP_W'(UNIT)) begin
                gap_q <= gap_q + GAP_W'(1);
            end
        end
    end

    // R6: pointer stays on record boundaries
    a_r6_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr_o % PTR_W'(REC_BYTES)) == '0);

    // R4: an output change only happens with a record advance
    a_r4_toggle_with_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (tone_o != $past(tone_o)) |-> (rd_ptr_o == $past(rd_ptr_o) + PTR_W'(REC_BYTES)));

    // R5: pointer holds while nothing is due
    a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !due_i |=> $stable(rd_ptr_o));

    // R5: two advances are at least one wait unit apart
    a_r5_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && moved) |-> (gap_q >= GAP_W'(UNIT - 1)));

    // R7: due on an empty ring freezes state and flags starvation
    a_r7_starve_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (due_i && rd_ptr_o == wr_ptr_i) |=> ($stable(tone_o) && $stable(rd_ptr_o) && underrun_o));

    // R8: starvation flag is sticky
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |=> underrun_o);

endmodule

bind toggle_player tgp_player_checker #(
    .TONE_W   (TONE_W),
    .REC_BYTES(REC_BYTES),
    .PTR_W    (PTR_W),
    .UNIT     (UNIT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .due_i     (due_w),
    .wr_ptr_i  (wr_ptr_i),
    .rd_ptr_o  (rd_ptr_o),
    .tone_o    (tone_o),
    .underrun_o(underrun_o)
);

// File: tb/toggle_player_tb_top.sv
`timescale 1ns/1ps
module toggle_player_tb_top;

    localparam int HOLD = 2048;
    localparam int UNIT = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] rec;
    logic [7:0]  wr_ptr = 8'd0;
    logic [7:0]  rd_ptr;
    logic [11:0] tone;
    logic        underrun;

    logic [31:0] ring [64];
    logic [15:0] src_mask [256];
    logic [7:0]  src_dly  [256];
    logic [7:0]  src_pad  [256];
    int          prod_total = 0;
    int          prod_idx   = 0;
    int          cyc = 0;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    assign rec = ring[rd_ptr[7:2]];

    toggle_player dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_i     (rec),
        .wr_ptr_i  (wr_ptr),
        .rd_ptr_o  (rd_ptr),
        .tone_o    (tone),
        .underrun_o(underrun)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Producer: one record per falling edge while a slot is free.
    task automatic produce_step();
        if (prod_idx < prod_total && (wr_ptr + 8'd4) != rd_ptr) begin
            ring[wr_ptr[7:2]] = {src_pad[prod_idx], src_dly[prod_idx], src_mask[prod_idx]};
            wr_ptr   = wr_ptr + 8'd4;
            prod_idx = prod_idx + 1;
        end
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) begin
            @(negedge clk);
            produce_step();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n      = 1'b0;
        prod_total = 0;
        prod_idx   = 0;
        wr_ptr     = 8'd0;
        for (int k = 0; k < 64; k++) ring[k] = 32'h0;
        repeat (3) @(negedge clk);
        chk("R1 tone in reset", 32'(tone), 32'h0);
        chk("R1 ptr in reset", 32'(rd_ptr), 32'h0);
        chk("R1 underrun in reset", 32'(underrun), 32'h0);
        rst_n = 1'b1;
    endtask

    // Plays prod_total records and checks every due edge and its predecessor.
    task automatic play_seq(input string tag);
        logic [11:0] exp_tone;
        int          e;
        exp_tone = 12'h0;
        e = HOLD;
        for (int i = 0; i < prod_total; i++) begin
            wait_cyc(e - 1);
            chk(i == 0 ? "R2 quiet before first" : "R5 quiet before due", 32'(tone), 32'(exp_tone));
            chk(i == 0 ? "R2 ptr before first" : "R5 ptr before due", 32'(rd_ptr), 32'((4 * i) & 255));
            wait_cyc(e);
            exp_tone = exp_tone ^ src_mask[i][11:0];
            chk(tag, 32'(tone), 32'(exp_tone));
            chk("R6 ptr step", 32'(rd_ptr), 32'((4 * (i + 1)) & 255));
            e = e + (int'(src_dly[i]) + 1) * UNIT;
        end
    endtask

    task automatic t_reset();
        do_reset();
        prod_total = 0;
        wait_cyc(5);
        chk("R1 tone after release", 32'(tone), 32'h0);
        chk("R1 ptr after release", 32'(rd_ptr), 32'h0);
        chk("R1 underrun after release", 32'(underrun), 32'h0);
    endtask

    task automatic t_spacing();
        logic [11:0] m [7] = '{12'h001, 12'hFFF, 12'h800, 12'h5A5, 12'h000, 12'h0F0, 12'h123};
        logic [7:0]  d [7] = '{8'd0, 8'd1, 8'd2, 8'd5, 8'd0, 8'd255, 8'd3};
        do_reset();
        for (int i = 0; i < 7; i++) begin
            src_mask[i] = {4'h0, m[i]};
            src_dly[i]  = d[i];
            src_pad[i]  = 8'h00;
        end
        prod_total = 7;
        play_seq("R4 xor apply");
    endtask

    task automatic t_layout();
        do_reset();
        src_mask[0] = 16'hF0A5; src_dly[0] = 8'd0; src_pad[0] = 8'hFF;
        src_mask[1] = 16'h3C00; src_dly[1] = 8'd1; src_pad[1] = 8'h5A;
        src_mask[2] = 16'hA00F; src_dly[2] = 8'd0; src_pad[2] = 8'h81;
        prod_total = 3;
        play_seq("R3 field layout");
    endtask

    task automatic t_wrap();
        do_reset();
        for (int i = 0; i < 70; i++) begin
            src_mask[i] = 16'((i * 37 + 1) & 12'hFFF);
            src_dly[i]  = 8'd0;
            src_pad[i]  = 8'h00;
        end
        prod_total = 70;
        play_seq("R6 wrap run");
    endtask

    task automatic t_underrun();
        do_reset();
        src_mask[0] = 16'h000F; src_dly[0] = 8'd0; src_pad[0] = 8'h00;
        src_mask[1] = 16'h00F0; src_dly[1] = 8'd3; src_pad[1] = 8'h00;
        src_mask[2] = 16'h0F00; src_dly[2] = 8'd1; src_pad[2] = 8'h00;
        src_mask[3] = 16'h0001; src_dly[3] = 8'd0; src_pad[3] = 8'h00;
        prod_total = 2;
        wait_cyc(HOLD + UNIT);
        chk("R7 second record", 32'(tone), 32'h0FF);
        wait_cyc(HOLD + UNIT + 4 * UNIT - 1);
        chk("R7 no flag before due", 32'(underrun), 32'h0);
        wait_cyc(HOLD + UNIT + 4 * UNIT);
        chk("R7 flag on empty due", 32'(underrun), 32'h1);
        chk("R7 tone held", 32'(tone), 32'h0FF);
        chk("R7 ptr held", 32'(rd_ptr), 32'h8);
        wait_cyc(HOLD + UNIT + 4 * UNIT + 30);
        chk("R7 still held", 32'(tone), 32'h0FF);
        chk("R7 ptr still held", 32'(rd_ptr), 32'h8);
        prod_total = 4;
        produce_step();
        produce_step();
        wait_cyc(HOLD + UNIT + 4 * UNIT + 31);
        chk("R7 late apply", 32'(tone), 32'hFFF);
        chk("R7 late ptr", 32'(rd_ptr), 32'hC);
        chk("R8 flag kept", 32'(underrun), 32'h1);
        wait_cyc(HOLD + UNIT + 4 * UNIT + 31 + 2 * UNIT - 1);
        chk("R9 quiet after late", 32'(tone), 32'hFFF);
        wait_cyc(HOLD + UNIT + 4 * UNIT + 31 + 2 * UNIT);
        chk("R9 spacing from late", 32'(tone), 32'hFFE);
        chk("R9 ptr", 32'(rd_ptr), 32'h10);
        chk("R8 flag still kept", 32'(underrun), 32'h1);
        do_reset();
        chk("R8 cleared by reset", 32'(underrun), 32'h0);
    endtask

    initial begin
        for (int k = 0; k < 64; k++) ring[k] = 32'h0;
        t_reset();
        t_spacing();
        t_layout();
        t_wrap();
        t_underrun();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule